// File: doc/BRIEF.md
# LCD Frame Sync Timing Generator

This block produces the vertical frame timing for a raster LCD panel. A programmable divider counts qualified pixel-clock enables and emits a one-cycle line tick at the end of every horizontal line. The line ticks are then counted up to a programmed frame length, and a vertical sync pulse is driven for the first one, two or three lines of each frame. A one-cycle frame-start strobe marks the first line tick of every frame.

Software sets the line divider, the frame length, the sync width code and the output polarity through a byte-wide write port. All four settings are held in shadow copies that are refreshed only at a frame boundary. A frame therefore never mixes old and new timing. Software is expected to program a frame length no shorter than the panel's visible lines plus its blank lines.

Top module: `lcd_fsync_gen`

## Requirements
- R1: While `rst` is high, `hsync_tick`, `vsync` and `frame_start` are 0 and every programmed field is cleared to 0. The first line tick after reset is released begins a frame.
- R2: With divider value LH, `hsync_tick` is high for one cycle after every LH+1 clock edges on which `pix_en` is sampled high. The tick appears in the cycle after the edge that samples the last of those enables, and it is never high unless `pix_en` was high in the cycle before.
- R3: With frame value LV, each frame lasts exactly LV+1 line ticks. `frame_start` is high in exactly the cycle of the first line tick of each frame, and in no other cycle.
- R4: The 2-bit width code W selects the active sync width: 00 gives 1 line, 01 gives 2 lines and 10 gives 3 lines. The active lines start on the frame's first line tick and are capped at LV+1 lines. `vsync` changes only in cycles where `hsync_tick` is high.
- R5: The reserved width code 11 gives an active width of 1 line.
- R6: When the polarity bit is 0, `vsync` is 1 on active lines and 0 on the other lines. When it is 1, the levels are swapped, so `vsync` is 0 on active lines.
- R7: Register map, written when `wr_en` is high:
  - address 0: bits 1:0 are the width code and bit 2 is the polarity bit.
  - address 1: LH bits 7:0.
  - address 2: LH bits 15:8.
  - address 3: LV bits 7:0.
  - address 4: LV bits 9:8, taken from data bits 1:0.
- R8: A write changes nothing in the frame that is running. The new LH, LV, width code and polarity all take effect together from the next frame start.
- R9: Data bits 7:3 at address 0, data bits 7:2 at address 4, and every write to addresses 5 to 7 have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable, one base pixel period per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| hsync_tick | output | 1 | One-cycle pulse at the end of each line |
| vsync | output | 1 | Vertical sync, polarity selectable |
| frame_start | output | 1 | One-cycle pulse on the first line tick of a frame |

## Verification
The assertions check on every cycle that `vsync` moves only with a line tick, that a line tick always follows a sampled pixel enable, and that the frame strobe always lands on a line tick. They also check that the strobe line carries the active sync level of the shadowed polarity, and that the line counter stays within the shadowed frame length. Only the bench scenarios can show the actual counts:
- line spacing in clocks
- frame length in lines, including the 1-line, 2-line and 1024-line cases
- active width for every code, including the cap by a short frame
- the deferral of a write made in the middle of a frame
- the absence of any effect from ignored bits and addresses

// File: rtl/lcd_fsync_pkg.sv
package lcd_fsync_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_LH_LO = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_LH_HI = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_LV_LO = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_LV_HI = 3'd4;

  typedef enum logic [1:0] {
    VW_ONE   = 2'b00,
    VW_TWO   = 2'b01,
    VW_THREE = 2'b10,
    VW_RSVD  = 2'b11
  } vwidth_e;

  typedef struct packed {
    vwidth_e wcode;
    logic    pol;
  } ctrl_t;

  // Active sync width in lines; the reserved code falls back to one line.
  function automatic logic [1:0] width_lines(vwidth_e c);
    case (c)
      VW_TWO:   return 2'd2;
      VW_THREE: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_fsync_regs.sv
module lcd_fsync_regs
  import lcd_fsync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LH_W   = 16,
  parameter int LV_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output ctrl_t                 cfg_ctrl,
  output logic [LH_W-1:0]       cfg_lh,
  output logic [LV_W-1:0]       cfg_lv
);

  localparam int LH_HI = LH_W - DATA_W;
  localparam int LV_HI = LV_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ctrl <= '0;
      cfg_lh   <= '0;
      cfg_lv   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_ctrl.wcode <= vwidth_e'(wr_data[1:0]);
          cfg_ctrl.pol   <= wr_data[2];
        end
        A_LH_LO: cfg_lh[DATA_W-1:0]    <= wr_data;
        A_LH_HI: cfg_lh[LH_W-1:DATA_W] <= wr_data[LH_HI-1:0];
        A_LV_LO: cfg_lv[DATA_W-1:0]    <= wr_data;
        A_LV_HI: cfg_lv[LV_W-1:DATA_W] <= wr_data[LV_HI-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lcd_fsync_hdiv.sv
module lcd_fsync_hdiv #(
  parameter int LH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_en,
  input  logic [LH_W-1:0] lh_limit,
  output logic            line_end,
  output logic            hsync_tick
);

  logic [LH_W-1:0] hcnt;

  assign line_end = pix_en && (hcnt == lh_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt       <= '0;
      hsync_tick <= 1'b0;
    end else begin
      hsync_tick <= line_end;
      if (pix_en) begin
        if (line_end) hcnt <= '0;
        else          hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_fsync_vgen.sv
module lcd_fsync_vgen
  import lcd_fsync_pkg::*;
#(
  parameter int LH_W = 16,
  parameter int LV_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  ctrl_t           cfg_ctrl,
  input  logic [LH_W-1:0] cfg_lh,
  input  logic [LV_W-1:0] cfg_lv,
  output logic [LH_W-1:0] lh_act,
  output logic [LV_W-1:0] lv_act,
  output logic            pol_act,
  output logic [LV_W-1:0] vcnt,
  output logic            vsync,
  output logic            frame_start
);

  vwidth_e         wcode_act;
  logic            wrap;
  logic [LV_W-1:0] vcnt_nx;
  vwidth_e         wcode_nx;
  logic            pol_nx;
  logic [1:0]      width_nx;
  logic            active_nx;

  always_comb begin
    wrap      = (vcnt == lv_act);
    vcnt_nx   = wrap ? '0 : vcnt + 1'b1;
    wcode_nx  = wrap ? cfg_ctrl.wcode : wcode_act;
    pol_nx    = wrap ? cfg_ctrl.pol : pol_act;
    width_nx  = width_lines(wcode_nx);
    active_nx = (vcnt_nx < {{(LV_W-2){1'b0}}, width_nx});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt        <= '0;
      lv_act      <= '0;
      lh_act      <= '0;
      wcode_act   <= VW_ONE;
      pol_act     <= 1'b0;
      vsync       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= line_end && wrap;
      if (line_end) begin
        vcnt  <= vcnt_nx;
        vsync <= active_nx ^ pol_nx;
        if (wrap) begin
          lv_act    <= cfg_lv;
          lh_act    <= cfg_lh;
          wcode_act <= cfg_ctrl.wcode;
          pol_act   <= cfg_ctrl.pol;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_fsync_gen.sv
module lcd_fsync_gen
  import lcd_fsync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LH_W   = 16,
  parameter int LV_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pix_en,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  hsync_tick,
  output logic                  vsync,
  output logic                  frame_start
);

  ctrl_t           cfg_ctrl;
  logic [LH_W-1:0] cfg_lh;
  logic [LV_W-1:0] cfg_lv;
  logic [LH_W-1:0] lh_act;
  logic [LV_W-1:0] lv_act;
  logic            pol_act;
  logic [LV_W-1:0] vcnt;
  logic            line_end;

  lcd_fsync_regs #(.DATA_W(DATA_W), .LH_W(LH_W), .LV_W(LV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg_ctrl (cfg_ctrl),
    .cfg_lh   (cfg_lh),
    .cfg_lv   (cfg_lv)
  );

  lcd_fsync_hdiv #(.LH_W(LH_W)) u_hdiv (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .lh_limit   (lh_act),
    .line_end   (line_end),
    .hsync_tick (hsync_tick)
  );

  lcd_fsync_vgen #(.LH_W(LH_W), .LV_W(LV_W)) u_vgen (
    .clk         (clk),
    .rst         (rst),
    .line_end    (line_end),
    .cfg_ctrl    (cfg_ctrl),
    .cfg_lh      (cfg_lh),
    .cfg_lv      (cfg_lv),
    .lh_act      (lh_act),
    .lv_act      (lv_act),
    .pol_act     (pol_act),
    .vcnt        (vcnt),
    .vsync       (vsync),
    .frame_start (frame_start)
  );

endmodule

// File: rtl/lcd_fsync_chk.sv
module lcd_fsync_chk #(
  parameter int LV_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            pix_en,
  input logic            hsync_tick,
  input logic            vsync,
  input logic            frame_start,
  input logic            pol_act,
  input logic [LV_W-1:0] vcnt,
  input logic [LV_W-1:0] lv_act
);

  p_tick_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    hsync_tick |-> $past(pix_en));

  p_fs_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> hsync_tick);

  p_vcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    vcnt <= lv_act);

  p_vsync_on_line_r4: assert property (@(posedge clk) disable iff (rst)
    !hsync_tick |-> $stable(vsync));

  p_fs_active_level_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (vsync != pol_act));

endmodule

bind lcd_fsync_gen lcd_fsync_chk #(.LV_W(LV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_en      (pix_en),
  .hsync_tick  (hsync_tick),
  .vsync       (vsync),
  .frame_start (frame_start),
  .pol_act     (pol_act),
  .vcnt        (vcnt),
  .lv_act      (lv_act)
);

// File: tb/tb_lcd_fsync_gen.sv
`timescale 1ns/1ps
module tb_lcd_fsync_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       hsync_tick, vsync, frame_start;

  int  nchecks = 0;
  int  nerrors = 0;
  bit  pix_toggle = 1'b0;

  // line monitor results
  int cur_len = 0, cur_high = 0, gap = 0;
  int last_len = 0, last_high = 0, last_gap = 0;

  always #2 clk = ~clk;

  lcd_fsync_gen dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_tick(hsync_tick), .vsync(vsync), .frame_start(frame_start)
  );

  typedef struct packed {
    logic [15:0] lh;
    logic [9:0]  lv;
    logic [1:0]  wc;
    logic        pol;
    logic [10:0] exp_len;
    logic [10:0] exp_act;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'd0,     10'd0,    2'd0, 1'b0, 11'd1,    11'd1},
    '{16'd2,     10'd1,    2'd1, 1'b0, 11'd2,    11'd2},
    '{16'd1,     10'd9,    2'd2, 1'b1, 11'd10,   11'd3},
    '{16'd0,     10'd9,    2'd3, 1'b0, 11'd10,   11'd1},
    '{16'd3,     10'd5,    2'd0, 1'b1, 11'd6,    11'd1},
    '{16'd0,     10'd1023, 2'd1, 1'b1, 11'd1024, 11'd2},
    '{16'd0,     10'd1,    2'd2, 1'b0, 11'd2,    11'd2},
    '{16'd0,     10'd4,    2'd2, 1'b0, 11'd5,    11'd3},
    '{16'h0102,  10'd2,    2'd1, 1'b0, 11'd3,    11'd2}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // pixel enable pattern
  initial begin
    forever begin
      @(negedge clk);
      pix_en <= pix_toggle ? ~pix_en : 1'b1;
    end
  end

  // line and frame monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        cur_len = 0; cur_high = 0; gap = 0;
      end else begin
        gap++;
        if (hsync_tick) begin
          last_gap = gap;
          gap = 0;
          if (frame_start) begin
            last_len  = cur_len;
            last_high = cur_high;
            cur_len   = 1;
            cur_high  = int'(vsync);
          end else begin
            cur_len++;
            cur_high += int'(vsync);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 190000);
    nerrors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_all(input logic [15:0] lh, input logic [9:0] lv,
                             input logic [1:0] wc, input logic pol);
    wr(3'd0, {5'b0, pol, wc});
    wr(3'd1, lh[7:0]);
    wr(3'd2, lh[15:8]);
    wr(3'd3, lv[7:0]);
    wr(3'd4, {6'b0, lv[9:8]});
  endtask

  task automatic wait_frame();
    @(negedge clk); #1;
    while (!frame_start) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic measure(input logic pol, input int exp_len, input int exp_act,
                         input int exp_gap, input string tag);
    int act;
    wait_frame();
    wait_frame();
    act = pol ? (last_len - last_high) : last_high;
    check(last_len == exp_len, {tag, " R3 R7 frame length"}, last_len, exp_len);
    check(act == exp_act, {tag, " R4 R5 R6 active width"}, act, exp_act);
    check(last_gap == exp_gap, {tag, " R2 line spacing"}, last_gap, exp_gap);
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(hsync_tick == 1'b0, "R1 reset hsync_tick", int'(hsync_tick), 0);
    check(vsync == 1'b0, "R1 reset vsync", int'(vsync), 0);
    check(frame_start == 1'b0, "R1 reset frame_start", int'(frame_start), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(frame_start == 1'b1, "R1 first tick starts frame", int'(frame_start), 1);
    check(vsync == 1'b1, "R1 first frame vsync active", int'(vsync), 1);

    // table of settings and expected counts
    for (int i = 0; i < NVEC; i++) begin
      program_all(VECS[i].lh, VECS[i].lv, VECS[i].wc, VECS[i].pol);
      measure(VECS[i].pol, int'(VECS[i].exp_len), int'(VECS[i].exp_act),
              int'(VECS[i].lh) + 1, $sformatf("vec%0d", i));
    end

    // R8: mid-frame write is deferred
    program_all(16'd0, 10'd9, 2'd0, 1'b0);
    wait_frame();
    wait_frame();
    wr(3'd3, 8'd4);
    wait_frame();
    check(last_len == 10, "R8 running frame keeps length", last_len, 10);
    wait_frame();
    check(last_len == 5, "R8 next frame uses new length", last_len, 5);

    // R9: ignored bits and addresses
    wr(3'd0, 8'hF8 | 8'h02);
    wr(3'd1, 8'd0);
    wr(3'd2, 8'd0);
    wr(3'd3, 8'd4);
    wr(3'd4, 8'hFC);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    measure(1'b0, 5, 3, 1, "R9 ignored bits");

    // R2: gated pixel enable halves the line rate
    pix_toggle = 1'b1;
    program_all(16'd1, 10'd2, 2'd0, 1'b0);
    measure(1'b0, 3, 1, 4, "R2 gated pix_en");
    pix_toggle = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule